// File: doc/BRIEF.md
# Serial ADC Read Controller

This block sits on the host side of a three-wire link to a 12-bit successive-approximation converter. It owns the active-low chip select and the serial clock. The converter takes its sample when chip select falls. It then shifts out a 16-bit word on falling serial clock edges: four zero bits, then the 12-bit straight-binary result, most significant bit first. A one-cycle `start_i` pulse asks for one conversion. The controller runs the frame, gathers the word and presents the 12-bit sample with a one-cycle valid strobe. An error flag is raised if a leading bit was not zero.

The controller also manages the converter's low-power state using chip-select timing alone. A `pd_req_i` pulse makes the controller run a short frame. In that frame chip select rises after the second falling serial clock edge, which puts the converter to sleep. A conversion requested while the converter sleeps first runs a full dummy frame and discards its result. The controller then waits a fixed number of system clocks for the converter to settle before it runs the real conversion. The power state is tracked inside the block and shown on `pd_o`.

The serial clock half period is `clk_div_i + 1` system clocks. The divider value is captured at the start of each frame. Requests that arrive while the controller is busy are held until it is free.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset, `cs_n_o` and `sclk_o` are high, `valid_o` is low and `pd_o` is 0, meaning the converter is powered up.
- R2: A conversion frame drives `cs_n_o` low for exactly 16 falling edges of `sclk_o`. Each serial clock half period lasts `clk_div_i + 1` system clocks. `sclk_o` is high whenever `cs_n_o` is high.
- R3: The controller samples 16 bits of `sdata_i`: the first before the first falling edge, the other 15 at rising edges. `data_o` holds the last 12 bits sampled, the first of them in bit 11. `valid_o` pulses for exactly one cycle, in the cycle that `cs_n_o` rises.
- R4: `err_o` goes high together with `valid_o` when any of the first four sampled bits is 1. `data_o` is still delivered in that case.
- R5: Between frames, `cs_n_o` stays high for at least `2*(clk_div_i+1)` system clocks.
- R6: A `pd_req_i` pulse while powered up runs a frame in which `cs_n_o` rises after the 2nd falling serial clock edge and before the 3rd. That frame gives no `valid_o`, and `pd_o` becomes 1 when it ends.
- R7: A start request while `pd_o` is 1 first runs a 16-edge dummy frame without `valid_o`, which clears `pd_o` as it ends. After the inter-frame gap the controller waits `WAKE_CYCLES` more system clocks, and only then starts the real conversion, which gives `valid_o`.
- R8: Start requests that arrive during a frame or during the wake wait are held pending and not dropped. All requests made before the next conversion begins merge into that one conversion.
- R9: When a conversion and a power-down are both pending, the conversion runs first. A `pd_req_i` pulse while `pd_o` is already 1 is ignored and starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle conversion request |
| pd_req_i | input | 1 | One-cycle request to put the converter to sleep |
| clk_div_i | input | DIV_W | Serial clock half period minus one, in system clocks |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idles high |
| data_o | output | DATA_W | Last conversion result, straight binary |
| valid_o | output | 1 | One-cycle strobe marking a new `data_o` |
| err_o | output | 1 | Leading bits of the last word were not all zero |
| pd_o | output | 1 | Tracked converter power state, 1 = asleep |

## Verification
A wrong half-frame counter shows up as a frame with a number of falling serial clock edges other than 16 or 2. The checker flags that in the cycle chip select rises. The bench flags it as a wrong edge count or as a shifted `data_o` at the next valid strobe. A stale power-state flag shows up within one frame. Either a conversion starts without the dummy frame and the wake wait, which the converter model in the bench records as an early or sleeping conversion, or a dummy frame runs needlessly and the valid count stays too low. A lost pending request shows up as a missing valid strobe, and the bench catches it by the end of its wait window.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FRAME,
        ST_GAP,
        ST_WAKE
    } ctrl_st_e;

    typedef enum logic [1:0] {
        K_CONV,
        K_DUMMY,
        K_PDOWN
    } frame_kind_e;

endpackage

// File: rtl/adc_rd_tick.sv
module adc_rd_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] lim_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] ph_d, ph_q;

    assign tick_o = run_i && (ph_q == lim_i);

    always_comb begin
        ph_d = ph_q;
        if (!run_i || tick_o) begin
            ph_d = '0;
        end else begin
            ph_d = ph_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_d;
        end
    end
endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);
    logic [W-1:0] sh_d, sh_q;

    assign word_o = sh_q;

    always_comb begin
        sh_d = sh_q;
        if (en_i) begin
            sh_d = {sh_q[W-2:0], bit_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int DATA_W      = 12,
    parameter int LEAD_W      = 4,
    parameter int PD_FALLS    = 2,
    parameter int WAKE_CYCLES = 125
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              pd_req_i,
    input  logic [DIV_W-1:0]  clk_div_i,
    input  logic              sdata_i,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              err_o,
    output logic              pd_o
);
    localparam int FRAME_BITS = DATA_W + LEAD_W;
    localparam int HALF_W     = $clog2(2 * FRAME_BITS);
    localparam int WK_W       = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;
    localparam logic [HALF_W-1:0] LAST_HALF   = HALF_W'(2 * FRAME_BITS - 1);
    localparam logic [HALF_W-1:0] LAST_SAMPLE = HALF_W'(2 * FRAME_BITS - 3);
    localparam logic [HALF_W-1:0] PD_HALF     = HALF_W'(2 * PD_FALLS - 1);
    localparam logic [WK_W-1:0]   WK_LAST     = WK_W'(WAKE_CYCLES - 1);

    typedef struct packed {
        ctrl_st_e          st;
        frame_kind_e       kind;
        logic [HALF_W-1:0] half;
        logic [DIV_W-1:0]  div;
        logic [WK_W-1:0]   wk;
        logic              pend_start;
        logic              pend_pd;
        logic              pd;
        logic              cs_n;
        logic              sclk;
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              err;
    } ctrl_t;

    ctrl_t r_q, r_d;

    logic                  tick;
    logic                  run;
    logic                  sample_en;
    logic                  frame_end;
    logic [FRAME_BITS-1:0] word;

    assign run       = (r_q.st == ST_FRAME) || (r_q.st == ST_GAP);
    assign sample_en = (r_q.st == ST_FRAME) && tick &&
                       ((r_q.half == '0) || (r_q.half[0] && (r_q.half <= LAST_SAMPLE)));
    assign frame_end = (r_q.half == LAST_HALF) ||
                       ((r_q.kind == K_PDOWN) && (r_q.half == PD_HALF));

    adc_rd_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (run),
        .lim_i (r_q.div),
        .tick_o(tick)
    );

    adc_rd_shift #(.W(FRAME_BITS)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (sample_en),
        .bit_i (sdata_i),
        .word_o(word)
    );

    always_comb begin
        r_d            = r_q;
        r_d.valid      = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (r_q.pend_start) begin
                    r_d.st   = ST_FRAME;
                    r_d.cs_n = 1'b0;
                    r_d.half = '0;
                    r_d.div  = clk_div_i;
                    if (r_q.pd) begin
                        r_d.kind = K_DUMMY;
                    end else begin
                        r_d.kind       = K_CONV;
                        r_d.pend_start = 1'b0;
                    end
                end else if (r_q.pend_pd) begin
                    r_d.pend_pd = 1'b0;
                    if (!r_q.pd) begin
                        r_d.st   = ST_FRAME;
                        r_d.cs_n = 1'b0;
                        r_d.half = '0;
                        r_d.div  = clk_div_i;
                        r_d.kind = K_PDOWN;
                    end
                end
            end
            ST_FRAME: begin
                if (tick) begin
                    if (frame_end) begin
                        r_d.st   = ST_GAP;
                        r_d.cs_n = 1'b1;
                        r_d.sclk = 1'b1;
                        r_d.half = '0;
                        case (r_q.kind)
                            K_CONV: begin
                                r_d.valid = 1'b1;
                                r_d.data  = word[DATA_W-1:0];
                                r_d.err   = |word[FRAME_BITS-1:DATA_W];
                            end
                            K_DUMMY: r_d.pd = 1'b0;
                            default: r_d.pd = 1'b1;
                        endcase
                    end else begin
                        r_d.sclk = ~r_q.sclk;
                        r_d.half = r_q.half + 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (r_q.half[0]) begin
                        r_d.st = (r_q.kind == K_DUMMY) ? ST_WAKE : ST_IDLE;
                        r_d.wk = '0;
                    end else begin
                        r_d.half = r_q.half + 1'b1;
                    end
                end
            end
            default: begin
                r_d.wk = r_q.wk + 1'b1;
                if (r_q.wk == WK_LAST) begin
                    r_d.st = ST_IDLE;
                end
            end
        endcase
        r_d.pend_start = r_d.pend_start | start_i;
        r_d.pend_pd    = r_d.pend_pd | pd_req_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.kind <= K_CONV;
            r_q.cs_n <= 1'b1;
            r_q.sclk <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cs_n_o  = r_q.cs_n;
    assign sclk_o  = r_q.sclk;
    assign data_o  = r_q.data;
    assign valid_o = r_q.valid;
    assign err_o   = r_q.err;
    assign pd_o    = r_q.pd;
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk #(
    parameter int DIV_W      = 8,
    parameter int FRAME_BITS = 16,
    parameter int PD_FALLS   = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] clk_div_i,
    input logic             cs_n_o,
    input logic             sclk_o,
    input logic             valid_o,
    input logic             pd_o
);
    localparam int FC_W = $clog2(FRAME_BITS + 1);
    localparam int GW   = DIV_W + 2;

    logic [FC_W-1:0] fall_q;
    logic            sclk_prev_q;
    logic [GW-1:0]   gap_q;
    logic [GW-1:0]   need;

    assign need = (GW'(clk_div_i) + 1'b1) << 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_q      <= '0;
            sclk_prev_q <= 1'b1;
            gap_q       <= '1;
        end else begin
            sclk_prev_q <= sclk_o;
            if (cs_n_o) begin
                fall_q <= '0;
                if (gap_q != '1) gap_q <= gap_q + 1'b1;
            end else begin
                gap_q <= '0;
                if (sclk_prev_q && !sclk_o) fall_q <= fall_q + 1'b1;
            end
        end
    end

    AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> sclk_o); // R2
    AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> (fall_q == FC_W'(FRAME_BITS) || fall_q == FC_W'(PD_FALLS))); // R2
    AST_VALID_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($rose(cs_n_o) && fall_q == FC_W'(FRAME_BITS))); // R3
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R3
    AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> (gap_q >= need)); // R5
    AST_PD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cs_n_o) && fall_q == FC_W'(PD_FALLS)) |-> (pd_o && !valid_o)); // R6
    AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_o) |-> ($rose(cs_n_o) && fall_q == FC_W'(FRAME_BITS) && !valid_o)); // R7
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(
    .DIV_W     (DIV_W),
    .FRAME_BITS(DATA_W + LEAD_W),
    .PD_FALLS  (PD_FALLS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_div_i(clk_div_i),
    .cs_n_o   (cs_n_o),
    .sclk_o   (sclk_o),
    .valid_o  (valid_o),
    .pd_o     (pd_o)
);

// File: tb/adc_rd_ctrl_bench.sv
`timescale 1ns/1ps
module adc_rd_ctrl_bench;
    localparam int WAKE = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        pd_req_i = 1'b0;
    logic [7:0]  clk_div_i = 8'd1;
    logic        sdata = 1'b0;
    logic        cs_n_o, sclk_o, valid_o, err_o, pd_o;
    logic [11:0] data_o;

    always #4 clk = ~clk;

    adc_rd_ctrl #(.WAKE_CYCLES(WAKE)) u_adc_rd_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pd_req_i(pd_req_i),
        .clk_div_i(clk_div_i), .sdata_i(sdata), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
        .data_o(data_o), .valid_o(valid_o), .err_o(err_o), .pd_o(pd_o)
    );

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // converter model
    logic [11:0] m_val = 12'h000;
    logic [3:0]  m_lead = 4'h0;
    logic [15:0] m_word = 16'h0;
    bit  m_down = 1'b0;
    bit  m_cs_prev = 1'b1;
    bit  m_woke = 1'b0;
    int  m_falls = 0;
    int  m_wake_t = 0;
    int  m_early = 0;

    always @(negedge cs_n_o or posedge cs_n_o or negedge sclk_o) begin
        if (!cs_n_o && m_cs_prev) begin
            m_falls = 0;
            m_word = m_down ? 16'hFFFF : {m_lead, m_val};
            sdata = m_word[15];
            if (!m_down && m_woke && (cyc - m_wake_t < WAKE)) m_early++;
        end else if (cs_n_o && !m_cs_prev) begin
            if (m_falls >= 2 && m_falls < 10) m_down = 1'b1;
            else if (m_falls >= 10 && m_down) begin
                m_down = 1'b0;
                m_woke = 1'b1;
                m_wake_t = cyc;
            end
            sdata = 1'b0;
        end else if (!cs_n_o && !sclk_o) begin
            m_falls++;
            if (m_falls < 16) sdata = m_word[15 - m_falls];
        end
        m_cs_prev = cs_n_o;
    end

    // port monitor, sampled away from the active edge
    int frames = 0, falls = 0, last_falls = 0, run = 0, hmin = 0, hmax = 0;
    int highcnt = 0, last_gap = 0, vcnt = 0;
    logic [11:0] last_data = '0;
    logic last_err = 1'b0;
    logic prev_cs = 1'b1, prev_sclk = 1'b1;

    always @(negedge clk) begin
        if (!cs_n_o && prev_cs) begin
            frames++; falls = 0; run = 1; hmin = 1000; hmax = 0;
            last_gap = highcnt;
        end else if (!cs_n_o) begin
            if (sclk_o != prev_sclk) begin
                if (run < hmin) hmin = run;
                if (run > hmax) hmax = run;
                run = 1;
                if (!sclk_o) falls++;
            end else run++;
        end
        if (cs_n_o && !prev_cs) begin
            last_falls = falls; highcnt = 0;
        end
        if (cs_n_o) highcnt++;
        if (valid_o) begin
            vcnt++; last_data = data_o; last_err = err_o;
        end
        prev_cs = cs_n_o;
        prev_sclk = sclk_o;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic pulse_pd();
        @(negedge clk) pd_req_i = 1'b1;
        @(negedge clk) pd_req_i = 1'b0;
    endtask

    task automatic wait_vcnt(input int target);
        for (int i = 0; i < 3000 && vcnt < target; i++) @(negedge clk);
    endtask

    task automatic settle();
        repeat (80) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(cs_n_o == 1'b1, "R1 cs_n in reset", cs_n_o, 1);
        chk(sclk_o == 1'b1, "R1 sclk in reset", sclk_o, 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(valid_o == 1'b0 && pd_o == 1'b0, "R1 valid/pd after reset",
            {valid_o, pd_o}, 0);
    endtask

    task automatic t_conv(input logic [11:0] val, input logic [3:0] lead,
                          input logic [7:0] div, input bit exp_err);
        int v0;
        clk_div_i = div;
        m_val = val;
        m_lead = lead;
        v0 = vcnt;
        pulse_start();
        wait_vcnt(v0 + 1);
        chk(vcnt == v0 + 1, "R3 one valid per start", vcnt - v0, 1);
        chk(last_data == val, "R3 data_o", last_data, val);
        chk(last_err == exp_err, "R4 err_o", last_err, exp_err);
        chk(last_falls == 16, "R2 falling edges per frame", last_falls, 16);
        chk(hmin == div + 1 && hmax == div + 1, "R2 half period", hmax, div + 1);
        settle();
    endtask

    task automatic t_pd();
        int v0, f0;
        v0 = vcnt;
        f0 = frames;
        pulse_pd();
        settle();
        chk(frames == f0 + 1, "R6 one power-down frame", frames - f0, 1);
        chk(last_falls == 2, "R6 cs rises after 2nd fall", last_falls, 2);
        chk(pd_o == 1'b1, "R6 pd_o set", pd_o, 1);
        chk(vcnt == v0, "R6 no valid", vcnt - v0, 0);
    endtask

    task automatic t_pd_ignored();
        int f0;
        f0 = frames;
        pulse_pd();
        settle();
        chk(frames == f0, "R9 pd_req while asleep ignored", frames - f0, 0);
        chk(pd_o == 1'b1, "R9 pd_o stays set", pd_o, 1);
    endtask

    task automatic t_wake(input logic [11:0] val);
        int v0, f0;
        m_val = val;
        m_lead = 4'h0;
        v0 = vcnt;
        f0 = frames;
        pulse_start();
        wait_vcnt(v0 + 1);
        settle();
        chk(vcnt == v0 + 1, "R7 dummy frame gives no valid", vcnt - v0, 1);
        chk(frames == f0 + 2, "R7 dummy plus real frame", frames - f0, 2);
        chk(last_data == val, "R7 data after wake", last_data, val);
        chk(pd_o == 1'b0, "R7 pd_o cleared", pd_o, 0);
        chk(m_early == 0, "R7 wake wait respected", m_early, 0);
    endtask

    task automatic t_pending();
        int v0;
        m_val = 12'h5A3;
        m_lead = 4'h0;
        v0 = vcnt;
        pulse_start();
        for (int i = 0; i < 100 && cs_n_o; i++) @(negedge clk);
        repeat (5) @(negedge clk);
        pulse_start();
        repeat (3) @(negedge clk);
        pulse_start();
        wait_vcnt(v0 + 2);
        settle();
        chk(vcnt == v0 + 2, "R8 pending start kept and merged", vcnt - v0, 2);
        chk(last_gap >= 2 * (clk_div_i + 1), "R5 cs high gap", last_gap,
            2 * (clk_div_i + 1));
    endtask

    task automatic t_both();
        int v0, f0;
        m_val = 12'h0F0;
        v0 = vcnt;
        f0 = frames;
        @(negedge clk) begin start_i = 1'b1; pd_req_i = 1'b1; end
        @(negedge clk) begin start_i = 1'b0; pd_req_i = 1'b0; end
        settle();
        chk(vcnt == v0 + 1 && last_data == 12'h0F0, "R9 conversion runs", last_data, 12'h0F0);
        chk(frames == f0 + 2 && last_falls == 2, "R9 power-down after conversion",
            last_falls, 2);
        chk(pd_o == 1'b1, "R9 asleep at end", pd_o, 1);
    endtask

    initial begin
        t_reset();
        t_conv(12'hA5C, 4'h0, 8'd1, 1'b0);
        t_conv(12'hFFF, 4'h0, 8'd0, 1'b0);
        t_conv(12'h000, 4'h0, 8'd3, 1'b0);
        t_conv(12'h123, 4'h8, 8'd2, 1'b1);
        t_conv(12'h801, 4'h1, 8'd1, 1'b1);
        t_pending();
        t_pd();
        t_pd_ignored();
        t_wake(12'h3C7);
        t_both();
        t_wake(12'h6B2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule